// File: doc/BRIEF.md
# System Reference Pulse Generator with Single-Ended Replica

This block derives system reference (SYSREF/1PPS) waveforms for a set of output channels from one fast input clock. Each channel owns a 12-bit clock divider whose divided clock is brought out directly. On most channels that divided clock also advances a 20-bit reference divider. After the reference divider comes a per-channel static delay of whole input-clock cycles, then a pulser. The pulser either passes the waveform through continuously or lets through a fixed number of pulses after each request. Two channels, chosen by a parameter, have only the clock divider.

A request from one of several source lines starts, or restarts, every divider in phase. The request is acted on at once, or is held until the next tick of a shared resampling divider, so that several reference outputs line up. A replication path copies the delayed but unpulsed reference waveform of one channel onto two single-ended GPIO outputs, each with its own enable. All configuration arrives on plain input ports and is expected to be static while a run is in progress.

Top module: `sysref_rep_gen`

## Requirements
- R1: After reset, `clk_o`, `sysref_o` and `gpio_o` are all low until the first request has been accepted.
- R2: Only a rising edge on `req_src_i[req_sel_i]` is a request. With `req_mode_i` equal to 2'b00, 2'b01 or 2'b10, the request is accepted immediately. If the selected line is sampled high at rising edge n after having been low, all counters restart at edge n+1, and outputs follow the new phase from that edge on.
- R3: With `req_mode_i` = 2'b11, a detected request waits for the shared resampling divider. That divider has ratio `rs_div_i` (0 counts as 1) and runs freely from reset. It ticks in the cycle after edge n when n mod ratio equals ratio-1, and the counters restart at the next edge.
- R4: `clk_o[i]` has period D1 = `cdiv_i[i]` input cycles (0 counts as 1). After a restart it is high first, for floor(D1/2) cycles, then low for the rest of the period. D1 = 1 gives a constant high.
- R5: The undelayed reference of a channel has period D1*D2 cycles, where D2 = `sdiv_i[i]` (0 counts as 1). For D2 >= 2 it is high first for floor(D2/2)*D1 cycles of each period. For D2 = 1 it equals the channel's divided clock.
- R6: The reference waveform is delayed by `dly_i[i]` input cycles (0 to 255) before the pulser and the replica tap.
- R7: With `pmode_i[i]` = 1, `sysref_o[i]` carries the first N high phases of the delayed waveform after a request and then stays low. N = `pcnt_i[i]`, and 0 counts as 1. With `pmode_i[i]` = 0 it is the delayed waveform itself.
- R8: On channels whose `HAS_SR` bit is 0 (channels 2 and 3 by default), `sysref_o` stays low and the `rep_en_i`, `sdiv_i`, `dly_i`, `pmode_i` and `pcnt_i` settings have no effect.
- R9: When `rep_en_i` is set on at least one channel that has a reference divider, `gpio_o[g]` with `gpio_oe_i[g]` = 1 carries the delayed waveform of the lowest-numbered such channel. This waveform is continuous even if that channel is in pulsed mode.
- R10: `gpio_o[g]` is low while `gpio_oe_i[g]` is 0, or while no channel with a reference divider has `rep_en_i` set.
- R11: A new request while running restarts all channel dividers together. The outputs then follow R4 and R5 counted from the new restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_src_i | input | SRC_N | Candidate request lines |
| req_sel_i | input | 2 | Index of the request line in use |
| req_mode_i | input | 2 | Request handling; 2'b11 resamples |
| rs_div_i | input | 12 | Shared resampling divider ratio |
| cdiv_i | input | NUM_CH*12 | Per-channel clock divider ratios |
| sdiv_i | input | NUM_CH*20 | Per-channel reference divider ratios |
| dly_i | input | NUM_CH*8 | Per-channel static delay in cycles |
| pmode_i | input | NUM_CH | Per-channel pulsed mode select |
| pcnt_i | input | NUM_CH*4 | Per-channel pulse count |
| rep_en_i | input | NUM_CH | Per-channel replication enable |
| gpio_oe_i | input | 2 | GPIO output enables |
| clk_o | output | NUM_CH | Divided channel clocks |
| sysref_o | output | NUM_CH | Channel reference outputs |
| gpio_o | output | 2 | Replicated reference outputs |

## Verification
The assertions assume that the ratios, delays, modes and counts stay constant between a reset and the next reset. They also assume that a pulsed channel sees at most one request per reset, and only with a waveform that has a low phase. In those conditions the pulse counter can only fall and the counter ranges hold. The stimulus applies every new configuration during reset and raises a single request line per run. The one exception is a restart run with zero delay in continuous mode. The stimulus also clears pulsed mode whenever the chosen ratios would give a constant-high waveform.

// File: rtl/sysref_gen_pkg.sv
package sysref_gen_pkg;
  localparam int CDIV_W = 12;
  localparam int SDIV_W = 20;
  localparam int DLY_W  = 8;
  localparam int PCNT_W = 4;
  localparam int GPIO_N = 2;

  typedef enum logic [1:0] {
    RQ_DIRECT   = 2'b00,
    RQ_ALT1     = 2'b01,
    RQ_ALT2     = 2'b10,
    RQ_RESAMPLE = 2'b11
  } req_mode_e;
endpackage

// File: rtl/sysref_req_ctrl.sv
module sysref_req_ctrl
  import sysref_gen_pkg::*;
#(
  parameter int SRC_N = 4,
  parameter int RS_W  = 12,
  localparam int SelW = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] src_i,
  input  logic [SelW-1:0]  sel_i,
  input  req_mode_e        mode_i,
  input  logic [RS_W-1:0]  rs_div_i,
  output logic             start_o,
  output logic             run_o
);
  logic            req_q, req_qq, pend_q, run_q;
  logic [RS_W-1:0] rs_cnt_q, rs_eff;
  logic            rs_tick, req_edge, resample;

  assign rs_eff   = (rs_div_i == '0) ? RS_W'(1) : rs_div_i;
  assign rs_tick  = rs_cnt_q >= rs_eff - RS_W'(1);
  assign req_edge = req_q & ~req_qq;
  assign resample = (mode_i == RQ_RESAMPLE);
  assign start_o  = resample ? ((pend_q | req_edge) & rs_tick) : req_edge;
  assign run_o    = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= 1'b0;
      req_qq   <= 1'b0;
      pend_q   <= 1'b0;
      run_q    <= 1'b0;
      rs_cnt_q <= '0;
    end else begin
      req_q    <= src_i[sel_i];
      req_qq   <= req_q;
      rs_cnt_q <= rs_tick ? '0 : rs_cnt_q + RS_W'(1);
      pend_q   <= resample & (pend_q | req_edge) & ~rs_tick;
      if (start_o) run_q <= 1'b1;
    end
  end

  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q); // R1
  AST_PEND_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && rs_tick) |=> !pend_q); // R3
endmodule

// File: rtl/sysref_chan_div.sv
module sysref_chan_div #(
  parameter int CW = 12,
  parameter int SW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          run_i,
  input  logic [CW-1:0] cdiv_i,
  input  logic [SW-1:0] sdiv_i,
  output logic          clk_o,
  output logic          sr_o
);
  logic [CW-1:0] c_cnt_q, c_eff;
  logic [SW-1:0] s_cnt_q, s_eff;
  logic          c_wrap, s_wrap;

  assign c_eff  = (cdiv_i == '0) ? CW'(1) : cdiv_i;
  assign s_eff  = (sdiv_i == '0) ? SW'(1) : sdiv_i;
  assign c_wrap = c_cnt_q >= c_eff - CW'(1);
  assign s_wrap = s_cnt_q >= s_eff - SW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_cnt_q <= '0;
      s_cnt_q <= '0;
    end else if (start_i) begin
      c_cnt_q <= '0;
      s_cnt_q <= '0;
    end else if (run_i) begin
      c_cnt_q <= c_wrap ? '0 : c_cnt_q + CW'(1);
      if (c_wrap) s_cnt_q <= s_wrap ? '0 : s_cnt_q + SW'(1);
    end
  end

  // odd ratios: high phase is the shorter one
  assign clk_o = run_i & ((c_eff == CW'(1)) | (c_cnt_q < (c_eff >> 1)));
  assign sr_o  = run_i & ((s_eff == SW'(1)) ? clk_o : (s_cnt_q < (s_eff >> 1)));

  AST_ALIGN_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (c_cnt_q == '0 && s_cnt_q == '0)); // R11
  AST_CDIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $stable(cdiv_i) && c_cnt_q < c_eff) |=> (c_cnt_q < c_eff)); // R4
endmodule

// File: rtl/sysref_dly_pulse.sv
module sysref_dly_pulse #(
  parameter int DW = 8,
  parameter int NW = 4,
  localparam int Depth = (1 << DW) - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          sr_i,
  input  logic [DW-1:0] dly_i,
  input  logic          pmode_i,
  input  logic [NW-1:0] pcnt_i,
  output logic          rep_o,
  output logic          pulse_o
);
  logic [Depth-1:0] line_q;
  logic [NW-1:0]    rem_q, n_eff;
  logic             rep_q, fall;

  assign rep_o = (dly_i == '0) ? sr_i : line_q[dly_i - DW'(1)];
  assign n_eff = (pcnt_i == '0) ? NW'(1) : pcnt_i;
  assign fall  = rep_q & ~rep_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      rep_q  <= 1'b0;
      rem_q  <= '0;
    end else begin
      line_q <= {line_q[Depth-2:0], sr_i};
      rep_q  <= rep_o;
      if (start_i)                    rem_q <= n_eff;
      else if (fall && rem_q != '0)   rem_q <= rem_q - NW'(1);
    end
  end

  assign pulse_o = pmode_i ? (rep_o & (rem_q != '0)) : rep_o;

  AST_REM_ONLY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (rem_q <= $past(rem_q))); // R7
endmodule

// File: rtl/sysref_rep_gen.sv
module sysref_rep_gen
  import sysref_gen_pkg::*;
#(
  parameter int              NUM_CH = 6,
  parameter int              SRC_N  = 4,
  parameter logic [NUM_CH-1:0] HAS_SR = 6'b110011,
  localparam int SelW = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SRC_N-1:0]         req_src_i,
  input  logic [SelW-1:0]          req_sel_i,
  input  logic [1:0]               req_mode_i,
  input  logic [CDIV_W-1:0]        rs_div_i,
  input  logic [NUM_CH*CDIV_W-1:0] cdiv_i,
  input  logic [NUM_CH*SDIV_W-1:0] sdiv_i,
  input  logic [NUM_CH*DLY_W-1:0]  dly_i,
  input  logic [NUM_CH-1:0]        pmode_i,
  input  logic [NUM_CH*PCNT_W-1:0] pcnt_i,
  input  logic [NUM_CH-1:0]        rep_en_i,
  input  logic [GPIO_N-1:0]        gpio_oe_i,
  output logic [NUM_CH-1:0]        clk_o,
  output logic [NUM_CH-1:0]        sysref_o,
  output logic [GPIO_N-1:0]        gpio_o
);
  logic              start, run;
  logic [NUM_CH-1:0] sr_w, rep_w;
  logic              rep_hit, rep_bit;
  req_mode_e         mode;

  assign mode = req_mode_e'(req_mode_i);

  sysref_req_ctrl #(.SRC_N(SRC_N), .RS_W(CDIV_W)) u_req (
    .clk_i, .rst_ni,
    .src_i(req_src_i), .sel_i(req_sel_i), .mode_i(mode), .rs_div_i,
    .start_o(start), .run_o(run)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    sysref_chan_div #(.CW(CDIV_W), .SW(SDIV_W)) u_div (
      .clk_i, .rst_ni, .start_i(start), .run_i(run),
      .cdiv_i(cdiv_i[i*CDIV_W +: CDIV_W]),
      .sdiv_i(sdiv_i[i*SDIV_W +: SDIV_W]),
      .clk_o(clk_o[i]), .sr_o(sr_w[i])
    );
    if (HAS_SR[i]) begin : g_sr
      sysref_dly_pulse #(.DW(DLY_W), .NW(PCNT_W)) u_dp (
        .clk_i, .rst_ni, .start_i(start), .sr_i(sr_w[i]),
        .dly_i(dly_i[i*DLY_W +: DLY_W]), .pmode_i(pmode_i[i]),
        .pcnt_i(pcnt_i[i*PCNT_W +: PCNT_W]),
        .rep_o(rep_w[i]), .pulse_o(sysref_o[i])
      );
    end else begin : g_nosr
      logic unused_ch;
      assign unused_ch   = ^{sr_w[i], sdiv_i[i*SDIV_W +: SDIV_W], dly_i[i*DLY_W +: DLY_W],
                             pmode_i[i], pcnt_i[i*PCNT_W +: PCNT_W]};
      assign rep_w[i]    = 1'b0;
      assign sysref_o[i] = 1'b0;
    end
  end

  // lowest enabled channel wins: scan downward, last hit kept
  always_comb begin
    rep_hit = 1'b0;
    rep_bit = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (rep_en_i[i] && HAS_SR[i]) begin
        rep_hit = 1'b1;
        rep_bit = rep_w[i];
      end
    end
  end

  assign gpio_o = gpio_oe_i & {GPIO_N{rep_hit & rep_bit}};

  AST_QUIET_PRE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (sysref_o == '0 && clk_o == '0 && gpio_o == '0)); // R1
  AST_NOSR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sysref_o & ~HAS_SR) == '0); // R8
endmodule

// File: tb/sysref_rep_gen_test.sv
`timescale 1ns/1ps
module sysref_rep_gen_test;
  localparam int NCH = 6;
  localparam logic [NCH-1:0] HASM = 6'b110011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0]       req_src;
  logic [1:0]       req_sel, req_mode;
  logic [11:0]      rs_div;
  logic [NCH*12-1:0] cdiv;
  logic [NCH*20-1:0] sdiv;
  logic [NCH*8-1:0]  dly;
  logic [NCH-1:0]    pmode, rep_en;
  logic [NCH*4-1:0]  pcnt;
  logic [1:0]        gpio_oe;
  logic [NCH-1:0]    clk_o, sysref_o;
  logic [1:0]        gpio_o;

  int d1[NCH], d2[NCH], dl[NCH], pn[NCH];
  bit pm[NCH], ren[NCH];
  bit [1:0] oe;
  int mode_c, rsd_c, sel_c;
  int cyc = 0, g_ns = 0, g_skip = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  sysref_rep_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .req_src_i(req_src), .req_sel_i(req_sel),
    .req_mode_i(req_mode), .rs_div_i(rs_div), .cdiv_i(cdiv), .sdiv_i(sdiv),
    .dly_i(dly), .pmode_i(pmode), .pcnt_i(pcnt), .rep_en_i(rep_en),
    .gpio_oe_i(gpio_oe), .clk_o(clk_o), .sysref_o(sysref_o), .gpio_o(gpio_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int eff(int v); return (v == 0) ? 1 : v; endfunction

  function automatic bit wave(int t, int a, int b);
    int p, h;
    if (t < 0) return 1'b0;
    p = a * b;
    if (b >= 2) h = (b / 2) * a;
    else h = (a == 1) ? 1 : a / 2;
    return (t % p) < h;
  endfunction

  function automatic bit rep_of(int ch, int m);
    return wave(m - g_ns - dl[ch], eff(d1[ch]), eff(d2[ch]));
  endfunction

  function automatic bit exp_sys(int ch, int m);
    int t, p;
    if (!HASM[ch]) return 1'b0;
    if (!rep_of(ch, m)) return 1'b0;
    if (!pm[ch]) return 1'b1;
    t = m - g_ns - dl[ch];
    p = eff(d1[ch]) * eff(d2[ch]);
    return (t / p) < eff(pn[ch]);
  endfunction

  function automatic bit exp_clk(int ch, int m);
    int t, a;
    t = m - g_ns; a = eff(d1[ch]);
    if (t < 0) return 1'b0;
    if (a == 1) return 1'b1;
    return (t % a) < (a / 2);
  endfunction

  function automatic logic [1:0] exp_gpio(int m);
    for (int i = 0; i < NCH; i++)
      if (ren[i] && HASM[i]) return oe & {2{rep_of(i, m)}};
    return 2'b00;
  endfunction

  function automatic int calc_ns(int n0);
    int rd, n;
    if (mode_c != 3) return n0 + 1;
    rd = eff(rsd_c); n = n0;
    while ((n % rd) != rd - 1) n++;
    return n + 1;
  endfunction

  task automatic chk(string tg, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", tg, cyc, act, exp);
    end
  endtask

  task automatic cmp_cycle(string ts, string tc, string tg);
    logic [NCH-1:0] es, ec;
    int m;
    m = cyc;
    if (m < g_skip) return;
    for (int i = 0; i < NCH; i++) begin es[i] = exp_sys(i, m); ec[i] = exp_clk(i, m); end
    if (m < g_ns) begin ts = "R1"; tc = "R1"; tg = "R1"; end
    chk({ts, " sysref_o"}, 32'(sysref_o), 32'(es));
    chk({tc, " clk_o"}, 32'(clk_o), 32'(ec));
    chk({tg, " gpio_o"}, 32'(gpio_o), 32'(exp_gpio(m)));
  endtask

  task automatic apply_cfg();
    for (int i = 0; i < NCH; i++) begin
      cdiv[i*12 +: 12] = 12'(d1[i]);
      sdiv[i*20 +: 20] = 20'(d2[i]);
      dly[i*8 +: 8]    = 8'(dl[i]);
      pcnt[i*4 +: 4]   = 4'(pn[i]);
      pmode[i]  = pm[i];
      rep_en[i] = ren[i];
    end
    gpio_oe = oe; req_mode = 2'(mode_c); rs_div = 12'(rsd_c); req_sel = 2'(sel_c);
  endtask

  task automatic setup();
    @(negedge clk); rst_n = 1'b0; req_src = '0;
    apply_cfg();
    g_ns = 1 << 30; g_skip = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic fire(int src);
    @(negedge clk);
    req_src[src] = 1'b1;
    if (src == sel_c) g_ns = calc_ns(cyc + 1);
  endtask

  task automatic sample(int w, string ts, string tc, string tg);
    for (int k = 0; k < w; k++) begin @(negedge clk); cmp_cycle(ts, tc, tg); end
  endtask

  task automatic base_cfg();
    for (int i = 0; i < NCH; i++) begin
      d1[i] = 2; d2[i] = 4; dl[i] = 0; pn[i] = 1; pm[i] = 0; ren[i] = 0;
    end
    oe = 2'b00; mode_c = 0; rsd_c = 1; sel_c = 0;
  endtask

  task automatic fix_pulsed();
    for (int i = 0; i < NCH; i++)
      if (eff(d1[i]) == 1 && eff(d2[i]) == 1) pm[i] = 0;
  endtask

  initial begin
    void'($urandom(32'h5A17C0DE));
    req_src = '0;

    // R2: non-selected source ignored, then selected source starts
    base_cfg(); sel_c = 1; d1[1] = 3; d2[0] = 6; ren[0] = 1; oe = 2'b11;
    setup();
    chk("R1 reset clk_o", 32'(clk_o), 0);
    chk("R1 reset sysref_o", 32'(sysref_o), 0);
    fire(2);
    repeat (8) @(negedge clk);
    chk("R2 wrong source clk_o", 32'(clk_o), 0);
    chk("R2 wrong source gpio_o", 32'(gpio_o), 0);
    fire(1);
    sample(60, "R2", "R2", "R9");

    // R4: odd, zero and unit clock ratios
    base_cfg(); d1[0] = 0; d1[1] = 5; d1[2] = 4; d1[3] = 3; d1[4] = 1; d1[5] = 7;
    d2[0] = 3; d2[4] = 5; mode_c = 2;
    setup(); fire(0); sample(80, "R5", "R4", "R10");

    // R6: long and medium delay
    base_cfg(); dl[0] = 255; dl[1] = 100; dl[4] = 7; ren[0] = 1; oe = 2'b01;
    d1[0] = 3; d2[0] = 5;
    setup(); fire(0); sample(330, "R6", "R4", "R6");

    // R7: pulse bursts, count 0 means one
    base_cfg(); pm[0] = 1; pn[0] = 0; pm[1] = 1; pn[1] = 3; d1[1] = 3; d2[1] = 3;
    pm[4] = 1; pn[4] = 15; d1[4] = 1; d2[4] = 2; pm[5] = 1; pn[5] = 2; d2[5] = 1; d1[5] = 4; dl[5] = 5;
    setup(); fire(0); sample(160, "R7", "R4", "R10");

    // R8/R9: divider-less channel enable ignored, pulsed source replicated continuously
    base_cfg(); ren[2] = 1; ren[4] = 1; ren[5] = 1; pm[4] = 1; pn[4] = 2; dl[4] = 3;
    pm[2] = 1; dl[2] = 9; d2[2] = 2; oe = 2'b11;
    setup(); fire(0); sample(80, "R8", "R4", "R9");

    // R10: output enable cleared on one pin, only divider-less channels enabled
    base_cfg(); ren[0] = 1; oe = 2'b10;
    setup(); fire(0); sample(40, "R5", "R4", "R10");
    base_cfg(); ren[3] = 1; oe = 2'b11;
    setup(); fire(0); sample(40, "R5", "R4", "R10");

    // R3: resampled request
    base_cfg(); mode_c = 3; rsd_c = 7; d1[1] = 3; ren[1] = 1; oe = 2'b01;
    setup(); repeat (4) @(negedge clk); fire(0); sample(60, "R3", "R3", "R3");
    base_cfg(); mode_c = 3; rsd_c = 0; sel_c = 3;
    setup(); fire(3); sample(30, "R3", "R3", "R3");
    base_cfg(); mode_c = 3; rsd_c = 11; sel_c = 2; d2[4] = 6;
    setup(); repeat (5) @(negedge clk); fire(2); sample(60, "R3", "R3", "R3");

    // R11: restart realigns
    base_cfg(); d1[0] = 3; d2[0] = 5; d1[1] = 4; ren[0] = 1; oe = 2'b11;
    setup(); fire(0); sample(23, "R11", "R11", "R11");
    @(negedge clk); req_src[0] = 1'b0;
    @(negedge clk); req_src[0] = 1'b1; g_ns = cyc + 2; g_skip = g_ns;
    sample(60, "R11", "R11", "R11");

    // random configurations
    for (int r = 0; r < 14; r++) begin
      for (int i = 0; i < NCH; i++) begin
        d1[i] = $urandom_range(0, 6); d2[i] = $urandom_range(0, 7);
        dl[i] = $urandom_range(0, 12); pm[i] = 1'($urandom_range(0, 1));
        pn[i] = $urandom_range(0, 5); ren[i] = ($urandom_range(0, 3) == 0);
      end
      oe = 2'($urandom_range(0, 3)); mode_c = $urandom_range(0, 3);
      rsd_c = $urandom_range(0, 9); sel_c = $urandom_range(0, 3);
      fix_pulsed();
      setup(); repeat ($urandom_range(0, 9)) @(negedge clk);
      fire(sel_c); sample(120, "R5", "R4", "R9");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule